// File: doc/BRIEF.md
# Page-Mode Flash Read Controller

This block sits between an internal read bus and an asynchronous parallel NOR flash. The flash has a 16-bit data bus, a 23-bit word address and 8-word pages. A read request carries a word address and uses a valid/ready handshake. The controller then drives chip enable, output enable, write enable and the address pins. It waits a fixed number of clock cycles, captures the data pins and returns the word with a one-cycle valid strobe.

The controller remembers which page is open. A read to a different page, or any read after chip enable has been released, waits the long initial-access time. That time is the larger of the initial-access count and the output-enable count. A read whose upper address bits match the open page, while chip enable is still low, waits only the short intra-page count. Chip enable and output enable stay low across back-to-back reads. The controller lets them go after a set number of idle cycles, and that also forgets the open page. The flash powers up in read-array mode, so no setup command is ever issued.

Top module: `pflash_rd`

## Requirements
- R1: After reset `flash_ce_n`, `flash_oe_n` and `flash_we_n` are 1, `req_ready` is 1 and `rsp_valid` is 0.
- R2: `flash_we_n` is always 1. `flash_oe_n` always equals `flash_ce_n`, so both are low together for every read.
- R3: A read that misses the open page has a fixed response time. Its word is captured at the clock edge that comes T_LONG = max(T_INIT, T_OE) edges after the accepting edge, and `rsp_valid` is 1 in the cycle after that capture edge. A miss is any read to a different page, or any read while no page is open.
- R4: A read whose address bits 22..3 equal those of the open page, with chip enable held low since that page was opened, is captured T_PAGE edges after the accepting edge.
- R5: `flash_addr` takes the full request address at the accepting edge and holds it until the capture. `rsp_data` equals the value on `flash_dq` at the capture edge.
- R6: `req_ready` is 0 only while a read is waiting. It is 1 in the cycle where `rsp_valid` is 1, so a new request offered in that cycle is accepted at once, with chip enable kept low.
- R7: After IDLE_REL consecutive cycles with chip enable low, `req_ready` 1 and no request accepted, `flash_ce_n` and `flash_oe_n` go to 1 and the open page is forgotten. The next read is a miss. IDLE_REL-1 such cycles leave the page open.
- R8: `rsp_valid` is a single-cycle pulse.
- R9: The first read after reset is a miss, whatever its address, including word 0 of page 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, must be released in step with clk |
| req_valid | input | 1 | A read request is offered |
| req_ready | output | 1 | A request can be taken this cycle |
| req_addr | input | 23 | Word address of the request |
| rsp_valid | output | 1 | `rsp_data` holds a returned word this cycle |
| rsp_data | output | 16 | Word read from the flash |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write enable, held high |
| flash_addr | output | 23 | Flash word address pins |
| flash_dq | input | 16 | Flash data pins |

## Verification
The bound checker runs a few age counters and checks them on every cycle. It checks that output enable follows chip enable, that no capture comes earlier than the long wait after a page change or a chip-enable fall, and that no capture comes earlier than the short wait after an accept. It also checks that the address holds while a read waits, that the response is a single pulse, and that chip enable rises only after exactly the idle limit. Those properties are lower bounds, so only the bench scenarios can show the exact latency of each read. The bench sweeps every word order of several pages, page boundaries, both address extremes, and idle gaps just below and at the release limit. A timing-aware flash stub poisons any data sampled early.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  typedef enum logic [1:0] {
    PFR_IDLE = 2'd0,
    PFR_OPEN = 2'd1,
    PFR_WAIT = 2'd2
  } pfr_state_e;
endpackage

// File: rtl/pfr_page_track.sv
// Holds the tag of the open page and whether it is still usable.
module pfr_page_track #(
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] tag_in,
  output logic             hit
);
  logic             valid_q, valid_d;
  logic [TAG_W-1:0] tag_q, tag_d;

  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    if (clr_en) begin
      valid_d = 1'b0;
    end else if (set_en) begin
      valid_d = 1'b1;
      tag_d   = tag_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
    end
  end

  assign hit = valid_q && (tag_q == tag_in);
endmodule

// File: rtl/pfr_wait_timer.sv
// Down-counter for the access wait; done flags the capture cycle.
module pfr_wait_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run_en,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_en) begin
      cnt_d = load_val;
    end else if (run_en && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = run_en && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/pfr_idle_timer.sv
// Counts idle open cycles; expire pulses on the LIMIT-th one.
module pfr_idle_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_en,
  input  logic tick_en,
  output logic expire
);
  localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign expire = tick_en && (cnt_q == CNT_W'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_en || expire) begin
      cnt_d = '0;
    end else if (tick_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pfr_seq.sv
// Read sequencer: state and the chip/output enable strobes.
module pfr_seq
  import pfr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       wait_done,
  input  logic       idle_expire,
  output pfr_state_e state,
  output logic       release_en,
  output logic       ce_n,
  output logic       oe_n
);
  pfr_state_e state_q, state_d;
  logic       ce_n_q, ce_n_d;

  assign release_en = (state_q == PFR_OPEN) && !accept && idle_expire;

  always_comb begin
    state_d = state_q;
    ce_n_d  = ce_n_q;
    unique case (state_q)
      PFR_IDLE: begin
        if (accept) begin
          state_d = PFR_WAIT;
          ce_n_d  = 1'b0;
        end
      end
      PFR_OPEN: begin
        if (accept) begin
          state_d = PFR_WAIT;
        end else if (idle_expire) begin
          state_d = PFR_IDLE;
          ce_n_d  = 1'b1;
        end
      end
      PFR_WAIT: begin
        if (wait_done) state_d = PFR_OPEN;
      end
      default: begin
        state_d = PFR_IDLE;
        ce_n_d  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PFR_IDLE;
      ce_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      ce_n_q  <= ce_n_d;
    end
  end

  assign state = state_q;
  assign ce_n  = ce_n_q;
  assign oe_n  = ce_n_q;
endmodule

// File: rtl/pflash_rd.sv
module pflash_rd
  import pfr_pkg::*;
#(
  parameter int ADDR_W   = 23,
  parameter int DATA_W   = 16,
  parameter int WORD_W   = 3,
  parameter int T_INIT   = 5,
  parameter int T_PAGE   = 2,
  parameter int T_OE     = 3,
  parameter int IDLE_REL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              flash_ce_n,
  output logic              flash_oe_n,
  output logic              flash_we_n,
  output logic [ADDR_W-1:0] flash_addr,
  input  logic [DATA_W-1:0] flash_dq
);
  localparam int TAG_W  = ADDR_W - WORD_W;
  localparam int T_LONG = (T_INIT > T_OE) ? T_INIT : T_OE;
  localparam int CNT_W  = $clog2(T_LONG + 1);

  pfr_state_e       state;
  logic             accept, page_hit, wait_done, idle_expire, release_en;
  logic             idle_tick;
  logic [CNT_W-1:0] wait_val;

  logic              rsp_valid_q, rsp_valid_d;
  logic [DATA_W-1:0] rsp_data_q, rsp_data_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  assign req_ready = (state != PFR_WAIT);
  assign accept    = req_valid && req_ready;
  assign idle_tick = (state == PFR_OPEN) && !accept;
  // Output enable has already been low for a full access on a hit.
  assign wait_val  = page_hit ? CNT_W'(T_PAGE) : CNT_W'(T_LONG);

  pfr_page_track #(.TAG_W(TAG_W)) u_page (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (accept),
    .clr_en (release_en),
    .tag_in (req_addr[ADDR_W-1:WORD_W]),
    .hit    (page_hit)
  );

  pfr_wait_timer #(.CNT_W(CNT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (accept),
    .load_val (wait_val),
    .run_en   (state == PFR_WAIT),
    .done     (wait_done)
  );

  pfr_idle_timer #(.LIMIT(IDLE_REL)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (state != PFR_OPEN),
    .tick_en (idle_tick),
    .expire  (idle_expire)
  );

  pfr_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .wait_done   (wait_done),
    .idle_expire (idle_expire),
    .state       (state),
    .release_en  (release_en),
    .ce_n        (flash_ce_n),
    .oe_n        (flash_oe_n)
  );

  always_comb begin
    addr_d      = addr_q;
    rsp_data_d  = rsp_data_q;
    rsp_valid_d = wait_done;
    if (accept)    addr_d     = req_addr;
    if (wait_done) rsp_data_d = flash_dq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q      <= '0;
      rsp_data_q  <= '0;
      rsp_valid_q <= 1'b0;
    end else begin
      addr_q      <= addr_d;
      rsp_data_q  <= rsp_data_d;
      rsp_valid_q <= rsp_valid_d;
    end
  end

  assign flash_addr = addr_q;
  assign rsp_data   = rsp_data_q;
  assign rsp_valid  = rsp_valid_q;
  assign flash_we_n = 1'b1;
endmodule

// File: rtl/pflash_rd_chk.sv
module pflash_rd_chk #(
  parameter int ADDR_W   = 23,
  parameter int WORD_W   = 3,
  parameter int T_INIT   = 5,
  parameter int T_PAGE   = 2,
  parameter int T_OE     = 3,
  parameter int IDLE_REL = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              flash_ce_n,
  input logic              flash_oe_n,
  input logic [ADDR_W-1:0] flash_addr
);
  localparam int T_LONG = (T_INIT > T_OE) ? T_INIT : T_OE;
  localparam int AGE_W  = $clog2(T_LONG + IDLE_REL + 2) + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic             acc;
  logic [AGE_W-1:0] ce_age, page_age, acc_age, idle_age;

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_age   <= '0;
      page_age <= '0;
      acc_age  <= '0;
      idle_age <= '0;
    end else begin
      ce_age   <= flash_ce_n ? '0 : (ce_age == AGE_MAX ? ce_age : ce_age + 1'b1);
      page_age <= (flash_ce_n || (acc && (req_addr[ADDR_W-1:WORD_W] != flash_addr[ADDR_W-1:WORD_W])))
                  ? '0 : (page_age == AGE_MAX ? page_age : page_age + 1'b1);
      acc_age  <= acc ? '0 : (acc_age == AGE_MAX ? acc_age : acc_age + 1'b1);
      idle_age <= (flash_ce_n || !req_ready || acc)
                  ? '0 : (idle_age == AGE_MAX ? idle_age : idle_age + 1'b1);
    end
  end

  AST_OE_FOLLOWS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    flash_oe_n == flash_ce_n); // R2

  AST_LONG_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (page_age >= AGE_W'(T_LONG)) && (ce_age >= AGE_W'(T_LONG))); // R3

  AST_SHORT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> acc_age >= AGE_W'(T_PAGE)); // R4

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(flash_addr)); // R5

  AST_READY_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready); // R6

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_ce_n) |-> idle_age == AGE_W'(IDLE_REL)); // R7

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8
endmodule

bind pflash_rd pflash_rd_chk #(
  .ADDR_W   (ADDR_W),
  .WORD_W   (WORD_W),
  .T_INIT   (T_INIT),
  .T_PAGE   (T_PAGE),
  .T_OE     (T_OE),
  .IDLE_REL (IDLE_REL)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .flash_ce_n (flash_ce_n),
  .flash_oe_n (flash_oe_n),
  .flash_addr (flash_addr)
);

// File: tb/pflash_rd_test.sv
`timescale 1ns/1ps
module pflash_rd_test;
  localparam int T_INIT   = 5;
  localparam int T_PAGE   = 2;
  localparam int T_OE     = 3;
  localparam int IDLE_REL = 4;
  localparam int T_LONG   = (T_INIT > T_OE) ? T_INIT : T_OE;
  localparam logic [15:0] POISON = 16'hDEAD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [22:0] req_addr = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        flash_ce_n, flash_oe_n, flash_we_n;
  logic [22:0] flash_addr;
  logic [15:0] flash_dq = POISON;

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  bit          open_valid = 1'b0;
  logic [19:0] open_page = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pflash_rd #(
    .T_INIT(T_INIT), .T_PAGE(T_PAGE), .T_OE(T_OE), .IDLE_REL(IDLE_REL)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n),
    .flash_addr(flash_addr), .flash_dq(flash_dq)
  );

  function automatic logic [15:0] pat(input logic [22:0] a);
    return {a[7:0], a[15:8]} ^ {a[22:16], 9'h0} ^ 16'h3C96;
  endfunction

  // Flash stub: drives the pattern only once every access time has elapsed.
  int ce_from = 0, oe_from = 0, addr_from = 0, page_from = 0;
  logic        prev_ce = 1'b1, prev_oe = 1'b1;
  logic [22:0] prev_addr = '0;
  always @(negedge clk) begin
    if (!flash_ce_n && prev_ce) begin ce_from = cyc; page_from = cyc; end
    if (!flash_oe_n && prev_oe) oe_from = cyc;
    if (flash_addr != prev_addr) addr_from = cyc;
    if (flash_addr[22:3] != prev_addr[22:3]) page_from = cyc;
    prev_ce = flash_ce_n; prev_oe = flash_oe_n; prev_addr = flash_addr;
    if (!flash_ce_n && !flash_oe_n && (cyc + 1 - ce_from >= T_INIT) &&
        (cyc + 1 - page_from >= T_INIT) && (cyc + 1 - addr_from >= T_PAGE) &&
        (cyc + 1 - oe_from >= T_OE))
      flash_dq = pat(flash_addr);
    else
      flash_dq = POISON;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_read(input logic [22:0] a);
    int    acc_edge, guard, exp_lat;
    bit    exp_hit;
    string rq;
    exp_hit = open_valid && (open_page == a[22:3]);
    exp_lat = exp_hit ? T_PAGE : T_LONG;
    rq      = exp_hit ? "R4" : "R3";
    if (exp_hit) check(flash_ce_n == 1'b0, "R6", "ce held low before hit", flash_ce_n, 0);
    req_valid = 1'b1;
    req_addr  = a;
    guard = 0;
    while (!req_ready && guard < 50) begin @(negedge clk); guard++; end
    acc_edge = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 100) begin @(negedge clk); guard++; end
    check(rsp_valid == 1'b1, rq, "response seen", rsp_valid, 1);
    check(cyc - acc_edge == exp_lat, rq, "latency", cyc - acc_edge, exp_lat);
    check(rsp_data != POISON, rq, "early sample flagged by stub", rsp_data, pat(a));
    check(rsp_data == pat(a), "R5", "data", rsp_data, pat(a));
    check(flash_addr == a, "R5", "address pins", flash_addr, a);
    check(!flash_ce_n && !flash_oe_n && flash_we_n, "R2", "strobes {ce,oe,we}",
          {flash_ce_n, flash_oe_n, flash_we_n}, 3'b001);
    check(req_ready == 1'b1, "R6", "ready with response", req_ready, 1);
    open_valid = 1'b1;
    open_page  = a[22:3];
  endtask

  task automatic idle(input int g);
    for (int i = 0; i < g; i++) begin
      @(negedge clk);
      if (i == 0) check(rsp_valid == 1'b0, "R8", "single-cycle response", rsp_valid, 0);
    end
    if (g >= IDLE_REL) open_valid = 1'b0;
    check(flash_ce_n == (g >= IDLE_REL), "R7", "ce after idle gap", flash_ce_n, g >= IDLE_REL);
    check(flash_oe_n == flash_ce_n, "R2", "oe tracks ce", flash_oe_n, flash_ce_n);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(flash_ce_n && flash_oe_n && flash_we_n, "R1", "strobes after reset",
          {flash_ce_n, flash_oe_n, flash_we_n}, 3'b111);
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R1", "no response after reset", rsp_valid, 0);

    // R9: first read after reset is a miss even at address 0
    do_read(23'h0);
    do_read(23'h1);

    // Sweep several pages, varying the word order inside each page.
    for (int p = 0; p < 8; p++) begin
      logic [19:0] pg;
      pg = 20'((p * 40503 + 7) % (1 << 20));
      for (int w = 0; w < 8; w++) begin
        int ww;
        ww = (p % 2 == 0) ? ((w * 3 + p) % 8) : (7 - w);
        do_read({pg, 3'(ww)});
      end
    end

    // Page boundary and address extremes
    do_read(23'h000007);
    do_read(23'h000008);
    do_read(23'h7FFFFF);
    do_read(23'h7FFFF8);

    // Idle gap one short of the limit keeps the page open
    idle(IDLE_REL - 1);
    do_read(23'h7FFFFA);
    // Idle gap at the limit releases chip enable; same page becomes a miss
    idle(IDLE_REL);
    do_read(23'h7FFFFA);
    do_read(23'h7FFFFB);
    idle(IDLE_REL + 3);
    do_read(23'h123456);

    @(negedge clk);
    check(rsp_valid == 1'b0, "R8", "pulse ends", rsp_valid, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule